// File: doc/BRIEF.md
# Training-Pattern Bitslip Byte Aligner

A deserializer that turns a serial lane into 8-bit words has no idea where the transmitter's byte boundaries fall. Any of eight bit offsets may be present. This block sits right after such a deserializer and recovers the framing. It keeps the previous word and joins it with the current one into a 16-bit window. Every valid cycle it tests all eight 8-bit slices of that window against a known training byte.

Training is requested by raising a train-enable input while the far end sends the training byte repeatedly. Once the same offset has matched on a run of consecutive valid words, that offset is locked and frozen. From then on every valid input word produces one correctly framed output byte, one cycle later. The lock holds until train-enable rises again.

Top module: `bitslip_aligner`

## Requirements
- R1: After reset, `aligned` is 0, `out_valid` is 0 and `offset` is 0.
- R2: The window is {current word, previous valid word}, with the previous word in bits 7:0. The candidate for offset k is window bits [k+7:k]. Once aligned, a valid input word gives `out_data` equal to the candidate at the locked offset on the next cycle. `out_data` holds its value on cycles without a valid input.
- R3: A candidate matches when it equals the PATTERN parameter (default 0x2F). Matching is only evaluated while `train_en` is high, the block is not aligned, and a previous word has been captured since the last restart.
- R4: The block becomes aligned, with `offset` set to k, on the valid word that completes LOCK_RUN (default 4) consecutive valid words matching at offset k. A word with no match, or with a match at a different offset, restarts the run. Cycles without a valid input neither advance nor break the run.
- R5: When several offsets match in the same word, the lowest offset is the one counted.
- R6: Once aligned, `offset` stays fixed, whatever the input data and whether `train_en` stays high or falls.
- R7: A rising edge on `train_en` clears `aligned` and the run on the next cycle. It also discards the stored previous word, so the first word after the restart cannot match.
- R8: `out_valid` is high exactly on the cycle after a valid input word that arrived while aligned. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Raw word from the deserializer |
| in_valid | input | 1 | `in_data` carries a word this cycle |
| train_en | input | 1 | Training request; a rising edge restarts the search |
| out_data | output | 8 | Framed byte |
| out_valid | output | 1 | `out_data` carries a new framed byte |
| aligned | output | 1 | Offset is locked |
| offset | output | 3 | Locked bit offset (0 to 7) |

## Verification
A wrong run counter or run offset shows up as `aligned` rising on the wrong word. The bench checks the exact word index: the fourth matching word, or the eighth when one training word is corrupted. A wrong locked offset, or a stale or wrongly captured previous word, corrupts every framed byte from the first `out_valid` onward. So it is caught within one word of lock, for each of the eight skews. A failure to freeze the lock, or to clear it on a restart, shows as `offset` or `aligned` changing during the data phase. It also shows as `aligned` still high one cycle after `train_en` rises.

// File: rtl/bitslip_pkg.sv
package bitslip_pkg;
    localparam int          DEF_WORD_W   = 8;
    localparam logic [7:0]  DEF_PATTERN  = 8'h2F;
    localparam int          DEF_LOCK_RUN = 4;
endpackage

// File: rtl/bitslip_taps.sv
// Produces every W-bit slice of the 2W-bit window, one per bit offset.
module bitslip_taps #(
    parameter int W = 8
) (
    input  logic [2*W-1:0]       window,
    output logic [W-1:0][W-1:0]  cand
);
    for (genvar k = 0; k < W; k++) begin : g_tap
        assign cand[k] = window[k +: W];
    end
endmodule

// File: rtl/bitslip_match.sv
// Compares every candidate with the training byte; lowest matching offset wins.
module bitslip_match #(
    parameter int             W       = 8,
    parameter int             OFF_W   = 3,
    parameter logic [W-1:0]   PATTERN = 8'h2F
) (
    input  logic [W-1:0][W-1:0]  cand,
    output logic                 hit,
    output logic [OFF_W-1:0]     hit_idx
);
    logic [W-1:0] hits;

    for (genvar k = 0; k < W; k++) begin : g_cmp
        assign hits[k] = (cand[k] == PATTERN);
    end

    always_comb begin
        hit_idx = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (hits[k]) hit_idx = OFF_W'(k);
        end
    end

    assign hit = |hits;

    // R5: the chosen offset matches and no lower offset does
    logic [W-1:0] below_mask;
    assign below_mask = (W'(1) << hit_idx) - W'(1);

    always_comb begin
        if (hit) begin
            a_r5_lowest_offset: assert (hits[hit_idx] && ((hits & below_mask) == '0))
                else $error("R5: offset priority violated");
        end
    end
endmodule

// File: rtl/bitslip_lock.sv
// Run counter and lock state: locks after LOCK_RUN consecutive hits at one offset.
module bitslip_lock #(
    parameter int OFF_W    = 3,
    parameter int LOCK_RUN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              train_en,
    input  logic              in_valid,
    input  logic              have_prev,
    input  logic              hit,
    input  logic [OFF_W-1:0]  hit_idx,
    output logic              locked,
    output logic [OFF_W-1:0]  offset,
    output logic              restart
);
    localparam int CNT_W = $clog2(LOCK_RUN + 1);

    typedef struct packed {
        logic              train;
        logic              locked;
        logic [OFF_W-1:0]  off;
        logic [OFF_W-1:0]  run_off;
        logic [CNT_W-1:0]  cnt;
    } lock_st_t;

    lock_st_t st_d, st_q;
    logic     searching;
    logic [CNT_W-1:0] cnt_next;

    assign restart   = train_en && !st_q.train;
    assign searching = train_en && !st_q.locked && in_valid && have_prev;

    always_comb begin
        st_d       = st_q;
        st_d.train = train_en;
        cnt_next   = CNT_W'(1);
        if (st_q.cnt != '0 && hit_idx == st_q.run_off) begin
            cnt_next = st_q.cnt + CNT_W'(1);
        end
        if (restart) begin
            st_d.locked  = 1'b0;
            st_d.off     = '0;
            st_d.run_off = '0;
            st_d.cnt     = '0;
        end else if (searching) begin
            if (hit) begin
                st_d.run_off = hit_idx;
                st_d.cnt     = cnt_next;
                if (cnt_next == CNT_W'(LOCK_RUN)) begin
                    st_d.locked = 1'b1;
                    st_d.off    = hit_idx;
                    st_d.cnt    = '0;
                end
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked = st_q.locked;
    assign offset = st_q.off;

    a_r6_offset_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked)) |-> $stable(offset))
        else $error("R6: offset moved while locked");

    a_r3_lock_needs_train: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(train_en))
        else $error("R3: lock without training");

    a_r4_lock_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(hit && in_valid && have_prev) && offset == $past(hit_idx)))
        else $error("R4: lock not caused by a matching word");

    a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_en) |=> !locked)
        else $error("R7: restart did not clear lock");
endmodule

// File: rtl/bitslip_aligner.sv
// Top: previous-word register, window, search, lock and framed output register.
module bitslip_aligner
    import bitslip_pkg::*;
#(
    parameter int                        W        = DEF_WORD_W,
    parameter logic [DEF_WORD_W-1:0]     PATTERN  = DEF_PATTERN,
    parameter int                        LOCK_RUN = DEF_LOCK_RUN,
    localparam int                       OFF_W    = $clog2(W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      in_data,
    input  logic              in_valid,
    input  logic              train_en,
    output logic [W-1:0]      out_data,
    output logic              out_valid,
    output logic              aligned,
    output logic [OFF_W-1:0]  offset
);
    typedef struct packed {
        logic [W-1:0]  prev;
        logic          have;
        logic [W-1:0]  odata;
        logic          ovalid;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [2*W-1:0]       window;
    logic [W-1:0][W-1:0]  cand;
    logic                 hit;
    logic [OFF_W-1:0]     hit_idx;
    logic                 locked;
    logic [OFF_W-1:0]     lock_off;
    logic                 restart;

    assign window = {in_data, st_q.prev};

    bitslip_taps #(.W(W)) u_taps (
        .window (window),
        .cand   (cand)
    );

    bitslip_match #(.W(W), .OFF_W(OFF_W), .PATTERN(W'(PATTERN))) u_match (
        .cand    (cand),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    bitslip_lock #(.OFF_W(OFF_W), .LOCK_RUN(LOCK_RUN)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .train_en  (train_en),
        .in_valid  (in_valid),
        .have_prev (st_q.have),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .locked    (locked),
        .offset    (lock_off),
        .restart   (restart)
    );

    always_comb begin
        st_d        = st_q;
        st_d.ovalid = in_valid && locked;
        if (in_valid && locked) begin
            st_d.odata = cand[lock_off];
        end
        if (restart) begin
            st_d.have = 1'b0;
        end else if (in_valid) begin
            st_d.prev = in_data;
            st_d.have = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_data  = st_q.odata;
    assign out_valid = st_q.ovalid;
    assign aligned   = locked;
    assign offset    = lock_off;

    a_r8_valid_after_locked_word: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(aligned && in_valid))
        else $error("R8: out_valid without an aligned input word");

    a_r8_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!aligned && !$past(aligned)) |-> !out_valid)
        else $error("R8: out_valid while unaligned");

    a_r2_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> $stable(out_data))
        else $error("R2: out_data changed without input");
endmodule

// File: tb/bitslip_aligner_test.sv
module bitslip_aligner_test;
    localparam int         T   = 12;
    localparam int         NW  = T + 20;
    localparam logic [7:0] PAT = 8'h2F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       train_en = 1'b0;
    logic [7:0] out_data;
    logic       out_valid;
    logic       aligned;
    logic [2:0] offset;

    logic [7:0] s_in = '0;
    logic       s_valid = 1'b0;
    logic       s_train = 1'b0;
    logic [7:0] s_out;
    logic       s_ovalid;
    logic       s_aligned;
    logic [2:0] s_offset;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    bitslip_aligner uut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .train_en(train_en), .out_data(out_data), .out_valid(out_valid),
        .aligned(aligned), .offset(offset)
    );

    bitslip_aligner #(.PATTERN(8'h55)) uut_sym (
        .clk(clk), .rst_n(rst_n), .in_data(s_in), .in_valid(s_valid),
        .train_en(s_train), .out_data(s_out), .out_valid(s_ovalid),
        .aligned(s_aligned), .offset(s_offset)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Logical byte b of the serial stream: training bytes, then arithmetic data.
    function automatic logic [7:0] sbyte(input int b, input int p);
        if (b < T) return PAT;
        return 8'((b * 37) + (p * 11) + 3);
    endfunction

    // Deserialized word n when the deserializer is skewed by p bits.
    function automatic logic [7:0] word(input int n, input int p, input bit brk);
        logic [7:0] w;
        logic [7:0] b;
        if (brk && n == 3) return 8'h00;
        for (int i = 0; i < 8; i++) begin
            b    = sbyte((8 * n + p + i) / 8, p);
            w[i] = b[(8 * n + p + i) % 8];
        end
        return w;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // mode 0: back-to-back, 1: idle cycle after each word, 2: corrupted training word 3
    task automatic run(input int p, input int mode);
        int lock_at = (mode == 2) ? 8 : 4;
        int k = (8 - p) % 8;
        bit exp_al;
        bit exp_ov;
        train_en = 1'b1;
        in_valid = 1'b0;
        step();
        chk("R7 aligned cleared by restart", int'(aligned), 0);
        chk("R8 out_valid after restart", int'(out_valid), 0);
        for (int n = 0; n < NW; n++) begin
            in_data  = word(n, p, mode == 2);
            in_valid = 1'b1;
            train_en = (n < T + 8);
            step();
            exp_al = (n >= lock_at);
            exp_ov = (n >= lock_at + 1);
            chk("R4 aligned timing", int'(aligned), int'(exp_al));
            if (exp_al) chk("R6 locked offset", int'(offset), k);
            chk("R8 out_valid", int'(out_valid), int'(exp_ov));
            if (exp_ov) chk("R2 framed byte", int'(out_data), int'(sbyte(n - 1 + (p > 0 ? 1 : 0), p)));
            if (mode == 1) begin
                in_valid = 1'b0;
                in_data  = 8'hFF;
                step();
                chk("R8 out_valid on idle", int'(out_valid), 0);
                chk("R4 aligned across idle", int'(aligned), int'(exp_al));
            end
        end
        in_valid = 1'b0;
        train_en = 1'b0;
        step();
    endtask

    // R5 with a rotation-symmetric pattern: several offsets match at once.
    task automatic sym_run(input logic [7:0] w, input int exp_off);
        s_train = 1'b1;
        s_valid = 1'b0;
        step();
        for (int n = 0; n < 6; n++) begin
            s_in    = w;
            s_valid = 1'b1;
            step();
            if (n == 3) chk("R5 not yet aligned", int'(s_aligned), 0);
        end
        chk("R5 aligned", int'(s_aligned), 1);
        chk("R5 lowest offset", int'(s_offset), exp_off);
        chk("R5 framed byte", int'(s_out), 8'h55);
        s_valid = 1'b0;
        s_train = 1'b0;
        step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 aligned at reset", int'(aligned), 0);
        chk("R1 out_valid at reset", int'(out_valid), 0);
        chk("R1 offset at reset", int'(offset), 0);
        rst_n = 1'b1;
        step();
        chk("R1 aligned after reset", int'(aligned), 0);
        for (int p = 0; p < 8; p++) run(p, 0);
        for (int p = 0; p < 8; p++) run(p, 1);
        for (int p = 0; p < 8; p++) run(p, 2);
        sym_run(8'h55, 0);
        sym_run(8'hAA, 1);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule